// File: doc/BRIEF.md
# Timer Channel Count Snapshot and Status Readback

This block holds the read side of one channel of a programmable interval timer. The counting element keeps running while software reads it over an 8-bit data path. A two-byte read of a count that is still changing can return halves of two different values. To prevent this, software first issues a count-latch command. The block then freezes a copy of the 16-bit count and hands it out one byte per read strobe. When that copy has been read in full, later reads return the live count again.

The block can also freeze a status byte. This byte holds the present level of the channel output, a flag that says the last written count has not yet reached the counting element, and the programmed access, operating-mode and BCD fields. When a status byte and a count snapshot are both pending, the status byte is read first and the count bytes follow it. A control-word write, decoded elsewhere, returns the byte pointer to the low byte and discards any pending snapshot. The counting logic and the address decoding sit outside this block.

Top module: `tmr_readback`

## Requirements
- R1: After reset no snapshot and no status is pending and the byte pointer is at the low byte, so with access mode 2'b11 the read bus shows bits 7:0 of the live count.
- R2: With nothing latched, reads return the live count. With access mode 2'b11 the reads alternate between the low byte (bits 7:0) and the high byte (bits 15:8), starting at the low byte.
- R3: A count-latch strobe captures the live count on that clock edge. The reads that follow return bytes of the captured value while the live count changes.
- R4: While a snapshot is pending, further count-latch strobes are ignored. This includes a strobe in the same cycle as the read that completes the snapshot.
- R5: Once every byte of a snapshot that the access mode calls for has been read, the snapshot is released and reads return the live count again.
- R6: Access mode 2'b01 returns only the low byte on every read, and access mode 2'b10 returns only the high byte. In both modes a snapshot is released by a single read.
- R7: Access mode 2'b00 reads like mode 2'b11 (alternating low byte, then high byte). In both modes a snapshot taken while the pointer is at the high byte is released by the one read of the high byte.
- R8: A control-word strobe returns the byte pointer to the low byte and discards a pending count snapshot and a pending status byte.
- R9: A status-latch strobe captures the status byte {OUT level at bit 7, null-count flag at bit 6, access mode at bits 5:4, operating mode at bits 3:1, BCD flag at bit 0}.
- R10: A captured status byte is held until it is read. Further status-latch strobes, and changes on the inputs that feed it, have no effect until then.
- R11: While a status byte is pending, it is returned before any count byte. Reading it does not move the count byte pointer.

Parameter legality (count width equal to one or two bytes, status fields filling one byte exactly) is checked when the design is elaborated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_live | input | 16 | Running count from the counting element |
| out_lvl | input | 1 | Present level of the channel output |
| cnt_null | input | 1 | High while a written count awaits loading |
| op_mode | input | 3 | Programmed operating mode |
| acc_mode | input | 2 | Programmed access mode: 01 low only, 10 high only, 11 or 00 low then high |
| bcd_sel | input | 1 | Programmed BCD counting flag |
| cw_wr | input | 1 | Control word written to this channel (one-cycle strobe) |
| latch_cmd | input | 1 | Count-latch command strobe |
| stat_cmd | input | 1 | Status-latch command strobe |
| rd_stb | input | 1 | Read strobe; consumes the byte shown on rd_data |
| rd_data | output | 8 | Byte that the current read returns |

## Verification
The hardest case to reach is a snapshot taken while the byte pointer is already at the high byte. The same applies to a count-latch strobe that arrives in the very cycle a read completes the snapshot. Both depend on the exact number of earlier reads. The vector table therefore walks the pointer through a known sequence of live reads before it issues those latch strobes. Status-before-count ordering is reached by raising both latch strobes in one cycle and then changing every status input before the read, so a byte that was not held stands out.

// File: rtl/tmr_rdbk_pkg.sv
package tmr_rdbk_pkg;
   // Access-mode codes; the byte sequencing depends on them
   typedef enum logic [1:0] {
      ACC_ALT0 = 2'b00,
      ACC_LO   = 2'b01,
      ACC_HI   = 2'b10,
      ACC_ALT  = 2'b11
   } acc_e;

   function automatic logic acc_is_alt(input logic [1:0] a);
      return (a == ACC_ALT) || (a == ACC_ALT0);
   endfunction
endpackage

// File: rtl/rdbk_snap.sv
module rdbk_snap #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cap_req,
   input  logic             release_i,
   input  logic [CNT_W-1:0] live,
   output logic             held,
   output logic [CNT_W-1:0] snap
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= 1'b0;
         snap <= '0;
      end else if (clr) begin
         held <= 1'b0;
      end else if (held) begin
         if (release_i) held <= 1'b0;
      end else if (cap_req) begin
         held <= 1'b1;
         snap <= live;
      end
   end

   // R3
   snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!held && cap_req && !clr) |=> (held && snap == $past(live)));

   // R4
   snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> $stable(snap));

   // R8
   snap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !held);
endmodule

// File: rtl/rdbk_stat.sv
module rdbk_stat #(
   parameter int BYTE_W    = 8,
   parameter int MODE_W    = 3,
   parameter int ACC_W     = 2,
   parameter bit STATUS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cap_req,
   input  logic              consume,
   input  logic              out_lvl,
   input  logic              cnt_null,
   input  logic [ACC_W-1:0]  acc_mode,
   input  logic [MODE_W-1:0] op_mode,
   input  logic              bcd_sel,
   output logic              st_valid,
   output logic [BYTE_W-1:0] st_byte
);
   localparam int FIELD_W = MODE_W + ACC_W + 3;

   initial begin
      stat_width_chk: assert (FIELD_W == BYTE_W)
         else $error("status fields must fill one byte");
   end

   generate
      if (STATUS_EN) begin : g_stat
         logic [BYTE_W-1:0] pack_w;
         logic              vld_q;
         logic [BYTE_W-1:0] byte_q;

         assign pack_w = {out_lvl, cnt_null, acc_mode, op_mode, bcd_sel};

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q  <= 1'b0;
               byte_q <= '0;
            end else if (clr) begin
               vld_q <= 1'b0;
            end else if (vld_q) begin
               if (consume) vld_q <= 1'b0;
            end else if (cap_req) begin
               vld_q  <= 1'b1;
               byte_q <= pack_w;
            end
         end

         assign st_valid = vld_q;
         assign st_byte  = byte_q;

         // R10
         stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_q && !consume && !clr) |=> (vld_q && $stable(byte_q)));

         // R9
         stat_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!vld_q && cap_req && !clr) |=> (byte_q[BYTE_W-1] == $past(out_lvl)
               && byte_q[BYTE_W-2] == $past(cnt_null) && byte_q[0] == $past(bcd_sel)));
      end else begin : g_nostat
         assign st_valid = 1'b0;
         assign st_byte  = '0;
      end
   endgenerate
endmodule

// File: rtl/rdbk_bytesel.sv
module rdbk_bytesel
   import tmr_rdbk_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int ACC_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              rd_stb,
   input  logic              st_valid,
   input  logic [BYTE_W-1:0] st_byte,
   input  logic              cnt_held,
   input  logic [CNT_W-1:0]  snap,
   input  logic [CNT_W-1:0]  live,
   input  logic [ACC_W-1:0]  acc_mode,
   output logic [BYTE_W-1:0] rd_data,
   output logic              cnt_release
);
   localparam int N_BYTES = CNT_W / BYTE_W;

   initial begin
      bytesel_width_chk: assert ((N_BYTES == 1 || N_BYTES == 2) && (N_BYTES * BYTE_W == CNT_W))
         else $error("count width must be one or two bytes");
      bytesel_acc_chk: assert (ACC_W == 2)
         else $error("access field must be two bits");
   end

   logic [CNT_W-1:0]  src;
   logic [BYTE_W-1:0] cnt_byte;
   logic              cnt_rd;
   logic              last_byte;

   assign src    = cnt_held ? snap : live;
   assign cnt_rd = rd_stb && !st_valid;

   generate
      if (N_BYTES == 2) begin : g_two
         logic ptr_hi;
         logic alt;
         logic sel_hi;

         assign alt       = acc_is_alt(acc_mode);
         assign sel_hi    = (acc_mode == ACC_HI) || (alt && ptr_hi);
         assign cnt_byte  = sel_hi ? src[CNT_W-1 -: BYTE_W] : src[BYTE_W-1:0];
         assign last_byte = !alt || ptr_hi;

         always_ff @(posedge clk) begin
            if (!rst_n)             ptr_hi <= 1'b0;
            else if (clr)           ptr_hi <= 1'b0;
            else if (cnt_rd && alt) ptr_hi <= !ptr_hi;
         end

         // R8
         ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> !ptr_hi);

         // R11
         ptr_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_stb && st_valid && !clr) |=> $stable(ptr_hi));

         // R7
         ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_rd && alt && !clr) |=> (ptr_hi != $past(ptr_hi)));
      end else begin : g_one
         assign cnt_byte  = src[BYTE_W-1:0];
         assign last_byte = 1'b1;
      end
   endgenerate

   assign cnt_release = cnt_rd && cnt_held && last_byte;
   assign rd_data     = st_valid ? st_byte : cnt_byte;
endmodule

// File: rtl/tmr_readback.sv
module tmr_readback #(
   parameter int CNT_W     = 16,
   parameter int BYTE_W    = 8,
   parameter int MODE_W    = 3,
   parameter int ACC_W     = 2,
   parameter bit STATUS_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_live,
   input  logic              out_lvl,
   input  logic              cnt_null,
   input  logic [MODE_W-1:0] op_mode,
   input  logic [ACC_W-1:0]  acc_mode,
   input  logic              bcd_sel,
   input  logic              cw_wr,
   input  logic              latch_cmd,
   input  logic              stat_cmd,
   input  logic              rd_stb,
   output logic [BYTE_W-1:0] rd_data
);
   logic              held;
   logic [CNT_W-1:0]  snap;
   logic              release_w;
   logic              st_valid;
   logic [BYTE_W-1:0] st_byte;
   logic              st_consume;

   assign st_consume = rd_stb && st_valid;

   rdbk_snap #(.CNT_W(CNT_W)) u_snap (
      .clk(clk), .rst_n(rst_n), .clr(cw_wr), .cap_req(latch_cmd),
      .release_i(release_w), .live(cnt_live), .held(held), .snap(snap)
   );

   rdbk_stat #(.BYTE_W(BYTE_W), .MODE_W(MODE_W), .ACC_W(ACC_W), .STATUS_EN(STATUS_EN)) u_stat (
      .clk(clk), .rst_n(rst_n), .clr(cw_wr), .cap_req(stat_cmd), .consume(st_consume),
      .out_lvl(out_lvl), .cnt_null(cnt_null), .acc_mode(acc_mode), .op_mode(op_mode),
      .bcd_sel(bcd_sel), .st_valid(st_valid), .st_byte(st_byte)
   );

   rdbk_bytesel #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .ACC_W(ACC_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .clr(cw_wr), .rd_stb(rd_stb), .st_valid(st_valid),
      .st_byte(st_byte), .cnt_held(held), .snap(snap), .live(cnt_live),
      .acc_mode(acc_mode), .rd_data(rd_data), .cnt_release(release_w)
   );

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (!held && !st_valid));

   // R5
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (held && release_w) |=> !held);
endmodule

// File: tb/tmr_readback_tb_top.sv
module tmr_readback_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] cnt_live;
   logic        out_lvl, cnt_null, bcd_sel;
   logic [2:0]  op_mode;
   logic [1:0]  acc_mode;
   logic        cw_wr, latch_cmd, stat_cmd, rd_stb;
   logic [7:0]  rd_data;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   tmr_readback dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_live(cnt_live), .out_lvl(out_lvl),
      .cnt_null(cnt_null), .op_mode(op_mode), .acc_mode(acc_mode), .bcd_sel(bcd_sel),
      .cw_wr(cw_wr), .latch_cmd(latch_cmd), .stat_cmd(stat_cmd), .rd_stb(rd_stb),
      .rd_data(rd_data)
   );

   // ops = {cw, latch, rd}; exp is rd_data before the edge; req is the requirement number
   typedef struct packed {
      logic [2:0]  ops;
      logic [1:0]  acc;
      logic [15:0] live;
      logic [7:0]  exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 29;
   localparam vec_t VECS [NV] = '{
      '{3'b100, 2'b11, 16'h1234, 8'h34, 4'd1},  // R1 pointer low
      '{3'b001, 2'b11, 16'h1234, 8'h34, 4'd2},  // R2 live low
      '{3'b001, 2'b11, 16'h1235, 8'h12, 4'd2},  // R2 live high
      '{3'b010, 2'b11, 16'hABCD, 8'hCD, 4'd2},  // R2 capture ABCD
      '{3'b001, 2'b11, 16'h1111, 8'hCD, 4'd3},  // R3 frozen low
      '{3'b011, 2'b11, 16'h2222, 8'hAB, 4'd3},  // R3 frozen high; latch ignored (R4)
      '{3'b001, 2'b11, 16'h3344, 8'h44, 4'd5},  // R5 live again
      '{3'b010, 2'b11, 16'h5566, 8'h55, 4'd7},  // R7 latch at high pointer
      '{3'b001, 2'b11, 16'h0000, 8'h55, 4'd7},  // R7 single read releases
      '{3'b010, 2'b11, 16'h7788, 8'h88, 4'd5},  // R5 live after release
      '{3'b010, 2'b11, 16'h9999, 8'h88, 4'd4},  // R4 second latch ignored
      '{3'b001, 2'b11, 16'h9999, 8'h88, 4'd4},
      '{3'b001, 2'b11, 16'h9999, 8'h77, 4'd4},  // R4 old value kept
      '{3'b100, 2'b01, 16'h4321, 8'h21, 4'd6},  // R6 low only
      '{3'b001, 2'b01, 16'h4321, 8'h21, 4'd6},
      '{3'b001, 2'b01, 16'h4321, 8'h21, 4'd6},
      '{3'b100, 2'b10, 16'h4321, 8'h43, 4'd6},  // R6 high only
      '{3'b001, 2'b10, 16'h4321, 8'h43, 4'd6},
      '{3'b001, 2'b10, 16'h4321, 8'h43, 4'd6},
      '{3'b010, 2'b10, 16'h6543, 8'h65, 4'd6},
      '{3'b001, 2'b10, 16'h0000, 8'h65, 4'd6},  // R6 one read releases
      '{3'b000, 2'b10, 16'h0000, 8'h00, 4'd6},
      '{3'b100, 2'b00, 16'hA1B2, 8'hB2, 4'd7},  // R7 mode 00 alternates
      '{3'b001, 2'b00, 16'hA1B2, 8'hB2, 4'd7},
      '{3'b001, 2'b00, 16'hA1B2, 8'hA1, 4'd7},
      '{3'b001, 2'b00, 16'hA1B2, 8'hB2, 4'd7},
      '{3'b010, 2'b11, 16'hC3D4, 8'hC3, 4'd7},
      '{3'b100, 2'b11, 16'h0F0E, 8'hC3, 4'd8},  // R8 cw clears latch and pointer
      '{3'b000, 2'b11, 16'h0F0E, 8'h0E, 4'd8}
   };

   task automatic check(input logic [7:0] exp, input string req);
      n_run++;
      if (rd_data !== exp) begin
         n_fail++;
         $display("FAIL %s: rd_data=%h expected %h", req, rd_data, exp);
      end
   endtask

   task automatic drive(input logic cw, input logic lat, input logic st, input logic rd);
      cw_wr = cw; latch_cmd = lat; stat_cmd = st; rd_stb = rd;
   endtask

   initial begin
      #100000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cnt_live = 16'hBEEF; acc_mode = 2'b11; op_mode = 3'b000;
      out_lvl = 1'b0; cnt_null = 1'b0; bcd_sel = 1'b0;
      drive(0, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 check(8'hEF, "R1");

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         acc_mode = VECS[i].acc;
         cnt_live = VECS[i].live;
         drive(VECS[i].ops[2], VECS[i].ops[1], 1'b0, VECS[i].ops[0]);
         #1 check(VECS[i].exp, $sformatf("R%0d vec%0d", VECS[i].req, i));
      end

      // R9 R11: status and count latched together; status comes first
      @(negedge clk);
      drive(0, 0, 0, 0);
      acc_mode = 2'b11; op_mode = 3'b101; out_lvl = 1'b1; cnt_null = 1'b0; bcd_sel = 1'b1;
      cnt_live = 16'h1357;
      drive(0, 1, 1, 0);
      @(negedge clk);
      drive(0, 0, 0, 0);
      // R10: change every status input and retrigger; held byte stays
      out_lvl = 1'b0; op_mode = 3'b010; cnt_null = 1'b1; bcd_sel = 1'b0; cnt_live = 16'hFFFF;
      drive(0, 0, 1, 0);
      #1 check(8'hBB, "R9");
      @(negedge clk);
      drive(0, 0, 0, 1);
      #1 check(8'hBB, "R10");
      @(negedge clk);
      drive(0, 0, 0, 1);
      #1 check(8'h57, "R11");  // pointer not moved by the status read
      @(negedge clk);
      drive(0, 0, 0, 1);
      #1 check(8'h13, "R11");
      @(negedge clk);
      drive(0, 0, 0, 0);
      #1 check(8'hFF, "R5");

      // R9: second layout with the null flag set
      @(negedge clk);
      drive(1, 0, 0, 0);
      acc_mode = 2'b01;
      @(negedge clk);
      drive(0, 0, 1, 0);
      @(negedge clk);
      drive(0, 0, 0, 0);
      #1 check(8'h54, "R9");

      // R8: control word discards a pending status byte
      @(negedge clk);
      drive(1, 0, 0, 0);
      @(negedge clk);
      drive(0, 0, 0, 0);
      #1 check(8'hFF, "R8");

      // R1: reset clears a pending snapshot
      @(negedge clk);
      acc_mode = 2'b11; cnt_live = 16'h2468;
      drive(0, 1, 0, 0);
      @(negedge clk);
      drive(0, 0, 0, 0);
      rst_n = 1'b0; cnt_live = 16'h8642;
      @(negedge clk);
      rst_n = 1'b1;
      #1 check(8'h42, "R1");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule